// File: doc/BRIEF.md
# GPIO Pin Configuration Register Bank

This block holds one 32-bit configuration word per GPIO pin and turns each word into the pad-side and interrupt-side controls for that pin. Software reaches it through a simple word-addressed register bus. Word index n selects pin n, which is byte offset 4*n from the bank base. A single 3-bit mode field sets both the pin direction and, for inputs, the interrupt sense type. A peripheral hand-over bit overrides that mode. A configuration-done flag keeps the pin in a safe state until software has finished setting it up.

The pad input is brought into the clock domain by a synchronizer chain. Its synchronized level is returned in bit 0 of every read and is also passed on to the interrupt detection logic. That logic also receives each pin's sense type and its interrupt group number (one of eight). Electrical pad settings and the peripheral functions themselves sit outside this block.

Top module: `gpcfg_bank`

## Requirements
- R1: After reset every stored word is 0: pad_oe, pad_out, periph_sel, irq_sense and irq_grp are all 0 for every pin.
- R2: A write with bus_addr = n (n < NUM_PINS) changes only pin n's word. The other pins' words and outputs are unchanged.
- R3: Stored fields are bit 0 (output value), bits 3:1 (mode), bit 5 (peripheral), bit 9 (config done) and bits 18:16 (interrupt group). Each reads back as written. Every other bit reads 0 and ignores writes.
- R4: While bit 9 of a pin's word is 0, that pin's pad_oe, pad_out, periph_sel and irq_sense are all 0, whatever the other fields hold.
- R5: pad_oe is 1 only when done = 1, peripheral = 0 and mode = 1. pad_out equals bit 0 when done = 1 and peripheral = 0, and is 0 otherwise.
- R6: With done = 1 and bit 5 = 1, periph_sel is 1 and pad_oe, pad_out and irq_sense are 0, whatever the mode field holds.
- R7: With done = 1 and peripheral = 0, irq_sense carries the mode value for modes 2 (level high), 3 (level low), 4 (rising), 5 (falling) and 6 (both edges). It is 0 for modes 0, 1 and 7.
- R8: irq_grp for a pin always equals bits 18:16 of its word.
- R9: A change on pad_in reaches pin_lvl after exactly two rising clock edges. It is not visible after one.
- R10: A read registers bus_rdata at the clock edge where bus_rd is sampled high. bus_rdata holds its value while bus_rd is low. A read of an index at or above NUM_PINS returns 0.
- R11: Bit 0 of read data is the synchronized pad level, not the stored output value. A write is visible on the pin outputs right after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word index (pin number) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_oe | output | NUM_PINS | Pad output enable per pin |
| pad_out | output | NUM_PINS | Pad output value per pin |
| periph_sel | output | NUM_PINS | Pin handed to its peripheral function |
| pin_lvl | output | NUM_PINS | Synchronized pad level, to interrupt detection |
| irq_sense | output | 3*NUM_PINS | Sense type per pin, 0 = none |
| irq_grp | output | 3*NUM_PINS | Interrupt group per pin |

## Verification
The pin outputs come straight from the stored words, so they are due one edge after a write. The bench samples them 1 ns after that edge. Read data also appears one edge after the read strobe and is sampled the same way. The synchronized pad level is checked at both the first and the second edge after a pad change: it must still hold the old value after one edge and show the new value after two. Readback of bit 0 is taken only after the chain has settled.

// File: rtl/gpcfg_pkg.sv
package gpcfg_pkg;
   localparam int          CFG_W    = 32;
   localparam int          B_OUTV   = 0;
   localparam int          B_MODE   = 1;
   localparam int          MODE_W   = 3;
   localparam int          B_PERIPH = 5;
   localparam int          B_DONE   = 9;
   localparam int          B_GRP    = 16;
   localparam int          GRP_W    = 3;
   localparam logic [31:0] CFG_MASK = 32'h0007_022F;

   typedef enum logic [2:0] {
      MODE_IN_ZERO = 3'd0,
      MODE_DRIVE   = 3'd1,
      MODE_LVL_HI  = 3'd2,
      MODE_LVL_LO  = 3'd3,
      MODE_RISE    = 3'd4,
      MODE_FALL    = 3'd5,
      MODE_EDGES   = 3'd6,
      MODE_IN_OFF  = 3'd7
   } pin_mode_e;

   typedef struct packed {
      logic [GRP_W-1:0] grp;
      logic             done;
      logic             periph;
      pin_mode_e        mode;
      logic             outv;
   } pin_cfg_t;

   function automatic pin_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      pin_cfg_t c;
      c.grp    = w[B_GRP +: GRP_W];
      c.done   = w[B_DONE];
      c.periph = w[B_PERIPH];
      c.mode   = pin_mode_e'(w[B_MODE +: MODE_W]);
      c.outv   = w[B_OUTV];
      return c;
   endfunction

   function automatic logic is_sense_mode(input pin_mode_e m);
      return (m != MODE_IN_ZERO) && (m != MODE_DRIVE) && (m != MODE_IN_OFF);
   endfunction
endpackage

// File: rtl/gpcfg_sync.sv
module gpcfg_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpcfg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpcfg_pin.sv
module gpcfg_pin
   import gpcfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_word,
   output logic             pad_oe,
   output logic             pad_out,
   output logic             periph_sel,
   output logic [2:0]       sense,
   output logic [GRP_W-1:0] grp
);
   logic [CFG_W-1:0] cfg_q;
   pin_cfg_t         cfg;
   logic             gpio_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (wr_en)
         cfg_q <= wdata & CFG_MASK;
   end

   assign cfg       = unpack_cfg(cfg_q);
   assign gpio_live = cfg.done && !cfg.periph;

   always_comb begin
      pad_oe     = gpio_live && (cfg.mode == MODE_DRIVE);
      pad_out    = gpio_live && cfg.outv;
      periph_sel = cfg.done && cfg.periph;
      sense      = (gpio_live && is_sense_mode(cfg.mode)) ? cfg.mode : 3'd0;
      grp        = cfg.grp;
   end

   assign cfg_word = cfg_q;

   assert_gate_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wdata[B_DONE] |=> !pad_oe && !pad_out && !periph_sel && (sense == 3'd0));

   assert_periph_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wdata[B_DONE] && wdata[B_PERIPH] |=> periph_sel && !pad_oe && !pad_out && (sense == 3'd0));

   assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_word));
endmodule

// File: rtl/gpcfg_bank.sv
module gpcfg_bank
   import gpcfg_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_oe,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   periph_sel,
   output logic [NUM_PINS-1:0]   pin_lvl,
   output logic [3*NUM_PINS-1:0] irq_sense,
   output logic [3*NUM_PINS-1:0] irq_grp
);
   localparam int MIN_ADDR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > 1024) begin : g_bad_pins
      $error("gpcfg_bank: NUM_PINS out of range");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("gpcfg_bank: ADDR_W too small for NUM_PINS");
   end

   logic [CFG_W-1:0] words [NUM_PINS];
   logic [31:0]      rd_mux;

   gpcfg_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_lvl)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpcfg_pin u_pin (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (bus_wr && (bus_addr == ADDR_W'(i))),
         .wdata      (bus_wdata),
         .cfg_word   (words[i]),
         .pad_oe     (pad_oe[i]),
         .pad_out    (pad_out[i]),
         .periph_sel (periph_sel[i]),
         .sense      (irq_sense[3*i +: 3]),
         .grp        (irq_grp[3*i +: 3])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (bus_addr == ADDR_W'(i))
            rd_mux = {words[i][31:1], pin_lvl[i]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd)
         bus_rdata <= rd_mux;
   end

   assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (bus_rdata & ~CFG_MASK) == 32'd0);

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   assert_oor_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && (int'(bus_addr) >= NUM_PINS) |=> bus_rdata == 32'd0);
endmodule

// File: tb/sim_gpcfg_bank.sv
module sim_gpcfg_bank;
   localparam int N  = 8;
   localparam int AW = 4;
   localparam logic [31:0] MASK = 32'h0007_022F;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_oe, pad_out, periph_sel, pin_lvl;
   logic [3*N-1:0] irq_sense, irq_grp;

   int vecs = 0;
   int errs = 0;
   logic [31:0] model [N];

   always #4 clk = ~clk;

   gpcfg_bank #(.NUM_PINS(N), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .periph_sel(periph_sel), .pin_lvl(pin_lvl),
      .irq_sense(irq_sense), .irq_grp(irq_grp));

   function automatic logic f_live(logic [31:0] c);
      return c[9] && !c[5];
   endfunction
   function automatic logic f_oe(logic [31:0] c);
      return f_live(c) && (c[3:1] == 3'd1);
   endfunction
   function automatic logic f_out(logic [31:0] c);
      return f_live(c) && c[0];
   endfunction
   function automatic logic f_psel(logic [31:0] c);
      return c[9] && c[5];
   endfunction
   function automatic logic [2:0] f_sense(logic [31:0] c);
      return (f_live(c) && c[3:1] >= 3'd2 && c[3:1] <= 3'd6) ? c[3:1] : 3'd0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic check_pin(int p, string req);
      check({req, " oe R5"},     32'(pad_oe[p]),         32'(f_oe(model[p])));
      check({req, " out R5"},    32'(pad_out[p]),        32'(f_out(model[p])));
      check({req, " psel R6"},   32'(periph_sel[p]),     32'(f_psel(model[p])));
      check({req, " sense R7"},  32'(irq_sense[3*p +: 3]), 32'(f_sense(model[p])));
      check({req, " grp R8"},    32'(irq_grp[3*p +: 3]), 32'(model[p][18:16]));
   endtask

   task automatic check_all(string req);
      for (int p = 0; p < N; p++) check_pin(p, req);
   endtask

   task automatic do_write(int a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      if (a < N) model[a] = d & MASK;
   endtask

   task automatic do_read(int a, output logic [31:0] rd);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = AW'(a);
      @(posedge clk); #1;
      bus_rd = 1'b0;
      rd = bus_rdata;
   endtask

   function automatic logic [31:0] exp_read(int p);
      return {model[p][31:1], pad_in[p]};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      logic [31:0] rd, hold;
      void'($urandom(32'd20240611));
      for (int p = 0; p < N; p++) model[p] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 oe", 32'(pad_oe), 0);
      check("R1 psel", 32'(periph_sel), 0);
      check("R1 sense", 32'(irq_sense), 0);
      check("R1 grp", 32'(irq_grp), 0);
      @(negedge clk); rst_n = 1'b1;
      do_read(3, rd);
      check("R1 readback", rd, 32'd0);

      // R4: drive mode without done keeps pad released
      do_write(2, 32'h0000_0003);
      check("R4 oe before done", 32'(pad_oe[2]), 0);
      check("R4 out before done", 32'(pad_out[2]), 0);
      do_write(2, 32'h0000_0203);
      check("R5 oe after done", 32'(pad_oe[2]), 1);
      check("R5 out after done", 32'(pad_out[2]), 1);
      // R6: peripheral override
      do_write(2, 32'h0000_0223);
      check("R6 psel", 32'(periph_sel[2]), 1);
      check("R6 oe overridden", 32'(pad_oe[2]), 0);
      // R7: each mode value
      for (int m = 0; m < 8; m++) begin
         do_write(5, 32'h0000_0200 | 32'(m << 1));
         check_pin(5, "R7 mode sweep");
      end
      // R3: reserved bits ignored, fields read back
      do_write(4, 32'hFFFF_FFFF);
      do_read(4, rd);
      check("R3 reserved bits", rd, 32'h0007_022E | 32'(pad_in[4]));
      check("R11 bit0 is pad level", 32'(rd[0]), 32'(pad_in[4]));
      // R8 group
      check("R8 grp all ones", 32'(irq_grp[12 +: 3]), 32'd7);
      // R10: out-of-range read and hold
      do_read(12, rd);
      check("R10 oor read", rd, 32'd0);
      do_write(12, 32'h0000_0203);
      check_all("R2 oor write ignored");
      do_read(4, rd);
      hold = rd;
      repeat (3) @(posedge clk); #1;
      check("R10 rdata hold", bus_rdata, hold);
      // R9: sync latency
      @(negedge clk); pad_in[6] = 1'b1;
      @(posedge clk); #1;
      check("R9 one edge", 32'(pin_lvl[6]), 0);
      @(posedge clk); #1;
      check("R9 two edges", 32'(pin_lvl[6]), 1);
      do_read(6, rd);
      check("R11 read pad level", rd, exp_read(6));

      // random phase
      for (int it = 0; it < 300; it++) begin
         int p;
         logic [31:0] d;
         p = int'($urandom_range(N - 1));
         d = $urandom;
         if ($urandom_range(3) != 0) d[9] = 1'b1;
         if ($urandom_range(2) == 0) d[5] = 1'b0;
         do_write(p, d);
         check_all("R2 random write");
         if ($urandom_range(3) == 0) begin
            @(negedge clk); pad_in = N'($urandom);
            repeat (2) @(posedge clk);
         end
         do_read(p, rd);
         check("R3 random readback", rd, exp_read(p));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule